// File: doc/BRIEF.md
# ROM Bank-Switch Register Array

This block follows the word stream of a 10-bit-word expansion bus with 16-bit addresses and records which of four ROM banks is active in each page pair. A page is 4K words and its number is the top four bits of the fetch address. Pages 6 through 15 form five pairs: an even page and the odd page above it. Each pair has one 2-bit bank register, so a switch made from either page of a pair moves both pages. Pages 0 to 5 are never banked.

A bank-enable opcode is a word with bits 9:8 equal to `01` and bits 5:0 all zero. The four such words are 0x100, 0x140, 0x180 and 0x1C0. When a valid fetch carries one of them, the register of the pair that holds the fetch address is loaded with a slot taken from bits 7:6 of the word. With `FIX_ORDER` = 0 the two bits are used as they are. With `FIX_ORDER` = 1 they are swapped, which puts the four opcodes back in their nominal bank order. For the current fetch address the block drives out the bank slot held for that page, and the external memory uses it to build its physical address. A calculator power-on pulse returns every register to slot 0. This keeps a stale bank from surviving an off/on cycle while the block itself stays powered.

The fetch stream is an observed bus, not a handshaked stream. It has no ready signal and cannot be held back: every cycle with `fetch_valid` high is consumed in that cycle.

Top module: `rom_bank_tracker`

## Requirements
- R1: While `rst_n` is low, every register holds slot 0, and `bank_sel` is 0 for every page.
- R2: A cycle with `pwr_on` high clears every register to slot 0 at the next clock edge. This overrides a bank-enable opcode fetched in the same cycle.
- R3: With `FIX_ORDER` = 0, opcode 0x100 loads slot 0, 0x140 loads slot 1, 0x180 loads slot 2 and 0x1C0 loads slot 3. The slot is word bits 7:6.
- R4: With `FIX_ORDER` = 1, opcode 0x100 loads slot 0, 0x180 loads slot 1, 0x140 loads slot 2 and 0x1C0 loads slot 3. The slot is word bit 6 followed by bit 7.
- R5: The register loaded is the one for the pair of the fetch page, fetch_addr[15:13]. Pages 2k and 2k+1 read the same register, whichever of the two issued the switch.
- R6: A bank-enable fetch changes no register other than the one of its own pair.
- R7: A fetch with `fetch_valid` low, or a word that is not one of the four opcodes, changes no register.
- R8: A switch takes effect from the cycle after the opcode fetch. During the opcode fetch itself, `bank_sel` still shows the old slot.
- R9: Pages 0 to 5 always give `bank_sel` = 0. An opcode fetched from those pages changes no register.
- R10: `bank_sel` follows `fetch_addr` in the same cycle, with no clock edge in between, for every page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus word clock |
| rst_n | input | 1 | Asynchronous external reset, active low |
| pwr_on | input | 1 | Calculator power-on pulse; synchronous clear of all bank registers |
| fetch_addr | input | 16 | Address of the current fetch |
| fetch_word | input | 10 | Word fetched at `fetch_addr` |
| fetch_valid | input | 1 | Marks `fetch_word` as a real fetch |
| bank_sel | output | 2 | Bank slot for the page of `fetch_addr` |

## Verification
The bench builds two copies from the same stimulus. One uses `FIX_ORDER` = 0 and the other uses `FIX_ORDER` = 1, so every opcode is checked against both slot orders in the same cycle. Both copies keep the default first banked page of 6. This brings in the boundary between unbanked page 5 and banked page 6, as well as the pairing of the topmost pages E and F.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  typedef logic [1:0] bank_t;

  // Bank-enable opcode: bits 9:8 = 01, bits 5:0 = 0, slot field in bits 7:6
  function automatic logic is_bank_op(input logic [9:0] w);
    return (w[9:8] == 2'b01) && (w[5:0] == 6'd0);
  endfunction

  function automatic bank_t op_slot(input logic [9:0] w, input bit fix_order);
    return fix_order ? {w[6], w[7]} : w[7:6];
  endfunction
endpackage

// File: rtl/rbs_op_decode.sv
module rbs_op_decode #(
  parameter int WORD_W    = 10,
  parameter bit FIX_ORDER = 1'b0
) (
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  output logic              hit,
  output rbs_pkg::bank_t    slot
);
  localparam int FIELD_LO = 6;

  logic [1:0] field;

  assign field = word[FIELD_LO+1:FIELD_LO];
  assign hit   = valid && (word[WORD_W-1:WORD_W-2] == 2'b01)
                 && (word[FIELD_LO-1:0] == '0);

  generate
    if (FIX_ORDER) begin : g_fixed
      assign slot = {field[0], field[1]};
    end else begin : g_direct
      assign slot = field;
    end
  endgenerate
endmodule

// File: rtl/rbs_pair_regs.sv
module rbs_pair_regs #(
  parameter int PAIR_W     = 3,
  parameter int FIRST_PAIR = 3,
  parameter int NUM_PAIRS  = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clr,
  input  logic                              wr_en,
  input  logic [PAIR_W-1:0]                 wr_pair,
  input  rbs_pkg::bank_t                    wr_slot,
  output rbs_pkg::bank_t [NUM_PAIRS-1:0]    banks
);
  generate
    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
      logic sel;
      assign sel = wr_en && (wr_pair == PAIR_W'(FIRST_PAIR + k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      banks[k] <= '0;
        else if (clr)    banks[k] <= '0;
        else if (sel)    banks[k] <= wr_slot;
      end
    end
  endgenerate
endmodule

// File: rtl/rbs_bank_mux.sv
module rbs_bank_mux #(
  parameter int PAIR_W     = 3,
  parameter int FIRST_PAIR = 3,
  parameter int NUM_PAIRS  = 5
) (
  input  rbs_pkg::bank_t [NUM_PAIRS-1:0] banks,
  input  logic [PAIR_W-1:0]              rd_pair,
  output rbs_pkg::bank_t                 bank_sel
);
  always_comb begin
    bank_sel = '0;
    for (int k = 0; k < NUM_PAIRS; k++) begin
      if (rd_pair == PAIR_W'(FIRST_PAIR + k)) bank_sel = banks[k];
    end
  end
endmodule

// File: rtl/rom_bank_tracker.sv
module rom_bank_tracker #(
  parameter int ADDR_W            = 16,
  parameter int WORD_W            = 10,
  parameter int PAGE_W            = 4,
  parameter int FIRST_BANKED_PAGE = 6,
  parameter bit FIX_ORDER         = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic              fetch_valid,
  output logic [1:0]        bank_sel
);
  localparam int PAIR_W     = PAGE_W - 1;
  localparam int ALL_PAIRS  = 2 ** PAIR_W;
  localparam int FIRST_PAIR = FIRST_BANKED_PAGE / 2;
  localparam int NUM_PAIRS  = ALL_PAIRS - FIRST_PAIR;

  logic [PAIR_W-1:0]              pair;
  logic                           op_hit;
  rbs_pkg::bank_t                 op_slot;
  logic                           wr_en;
  rbs_pkg::bank_t [NUM_PAIRS-1:0] banks;
  rbs_pkg::bank_t                 sel;

  assign pair  = fetch_addr[ADDR_W-1 -: PAIR_W];
  assign wr_en = op_hit && (pair >= PAIR_W'(FIRST_PAIR));

  rbs_op_decode #(.WORD_W(WORD_W), .FIX_ORDER(FIX_ORDER)) u_dec (
    .valid (fetch_valid),
    .word  (fetch_word),
    .hit   (op_hit),
    .slot  (op_slot)
  );

  rbs_pair_regs #(.PAIR_W(PAIR_W), .FIRST_PAIR(FIRST_PAIR), .NUM_PAIRS(NUM_PAIRS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (pwr_on),
    .wr_en   (wr_en),
    .wr_pair (pair),
    .wr_slot (op_slot),
    .banks   (banks)
  );

  rbs_bank_mux #(.PAIR_W(PAIR_W), .FIRST_PAIR(FIRST_PAIR), .NUM_PAIRS(NUM_PAIRS)) u_mux (
    .banks    (banks),
    .rd_pair  (pair),
    .bank_sel (sel)
  );

  assign bank_sel = sel;
endmodule

// File: rtl/rbs_checker.sv
module rbs_checker #(
  parameter bit FIX_ORDER = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        pwr_on,
  input logic [15:0] fetch_addr,
  input logic [9:0]  fetch_word,
  input logic        fetch_valid,
  input logic [1:0]  bank_sel
);
  // R2
  pwr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_on |=> bank_sel == 2'd0);

  // R9
  low_page_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_addr[15:12] < 4'd6 |-> bank_sel == 2'd0);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_on && !(fetch_valid && rbs_pkg::is_bank_op(fetch_word)))
    |=> (!$stable(fetch_addr[15:13]) || $stable(bank_sel)));

  // R3 R4 R5
  slot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_on && fetch_valid && rbs_pkg::is_bank_op(fetch_word) && fetch_addr[15:12] >= 4'd6)
    |=> (!$stable(fetch_addr[15:13])
         || bank_sel == rbs_pkg::op_slot($past(fetch_word), FIX_ORDER)));
endmodule

bind rom_bank_tracker rbs_checker #(.FIX_ORDER(FIX_ORDER)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_on      (pwr_on),
  .fetch_addr  (fetch_addr),
  .fetch_word  (fetch_word),
  .fetch_valid (fetch_valid),
  .bank_sel    (bank_sel)
);

// File: tb/tb_rom_bank_tracker.sv
module tb_rom_bank_tracker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_on = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic [9:0]  fetch_word = '0;
  logic [1:0]  sel_raw, sel_fix;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [1:0] m_raw [8];
  logic [1:0] m_fix [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_bank_tracker #(.FIX_ORDER(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .fetch_addr(fetch_addr),
    .fetch_word(fetch_word), .fetch_valid(fetch_valid), .bank_sel(sel_raw));

  rom_bank_tracker #(.FIX_ORDER(1'b1)) dut_fix (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .fetch_addr(fetch_addr),
    .fetch_word(fetch_word), .fetch_valid(fetch_valid), .bank_sel(sel_fix));

  function automatic logic [1:0] exp_sel(input bit fix, input logic [15:0] a);
    if (a[15:12] < 4'd6) return 2'd0;
    return fix ? m_fix[a[15:13]] : m_raw[a[15:13]];
  endfunction

  function automatic bit is_op(input logic [9:0] w);
    return w == 10'h100 || w == 10'h140 || w == 10'h180 || w == 10'h1C0;
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 8; i++) begin m_raw[i] = 2'd0; m_fix[i] = 2'd0; end
  endtask

  // One fetch cycle: checks the pre-edge output (R8, R10), then updates the model
  task automatic cycle(input logic [15:0] a, input logic [9:0] w, input bit v, input bit p,
                       input string req);
    @(negedge clk);
    fetch_addr = a; fetch_word = w; fetch_valid = v; pwr_on = p;
    #1;
    check({req, " raw"}, sel_raw, exp_sel(1'b0, a));
    check({req, " fix"}, sel_fix, exp_sel(1'b1, a));
    @(posedge clk);
    if (rst_n) begin
      if (p) clear_model();
      else if (v && is_op(w) && a[15:12] >= 4'd6) begin
        // R3 direct order: bits 7:6; R4 fixed order: bits swapped
        m_raw[a[15:13]] = w[7:6];
        m_fix[a[15:13]] = {w[6], w[7]};
      end
    end
  endtask

  task automatic sweep(input string req);
    for (int p = 0; p < 16; p++)
      cycle({p[3:0], 12'($urandom)}, {1'b1, 9'($urandom)}, 1'b1, 1'b0, req);
  endtask

  task automatic peek(input logic [15:0] a, input logic [1:0] er, input logic [1:0] ef,
                      input string req);
    @(negedge clk);
    fetch_addr = a; fetch_valid = 1'b0; pwr_on = 1'b0;
    #1;
    check({req, " raw"}, sel_raw, er);
    check({req, " fix"}, sel_fix, ef);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R10: watchdog expired, actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [9:0] ops [4];
    ops[0] = 10'h100; ops[1] = 10'h140; ops[2] = 10'h180; ops[3] = 10'h1C0;
    void'($urandom(32'd2059));
    clear_model();

    // R1: reset state across all pages, even with opcodes on the bus
    cycle(16'h8000, 10'h1C0, 1'b1, 1'b0, "R1");
    sweep("R1");
    rst_n = 1'b1;

    // R3 R4: each opcode at page 8, explicit slot values
    cycle(16'h8010, 10'h180, 1'b1, 1'b0, "R8");
    peek(16'h8020, 2'd2, 2'd1, "R3 R4 0x180");
    cycle(16'h8030, 10'h140, 1'b1, 1'b0, "R8");
    peek(16'h8040, 2'd1, 2'd2, "R3 R4 0x140");
    cycle(16'h8050, 10'h1C0, 1'b1, 1'b0, "R8");
    peek(16'h8060, 2'd3, 2'd3, "R3 R4 0x1C0");
    cycle(16'h8070, 10'h100, 1'b1, 1'b0, "R8");
    peek(16'h8080, 2'd0, 2'd0, "R3 R4 0x100");

    // R5: switch from odd page B, read even page A
    cycle(16'hB123, 10'h180, 1'b1, 1'b0, "R8");
    peek(16'hA456, 2'd2, 2'd1, "R5 sibling");
    // R6: pair 8/9 untouched
    peek(16'h9000, 2'd0, 2'd0, "R6 other pair");
    // R8: opcode cycle itself still served from old slot (checked inside cycle)
    cycle(16'hA000, 10'h1C0, 1'b1, 1'b0, "R8 old slot");
    peek(16'hB000, 2'd3, 2'd3, "R8 new slot");

    // R7: invalid strobe and near-miss words change nothing
    cycle(16'hC000, 10'h140, 1'b0, 1'b0, "R7");
    cycle(16'hC000, 10'h141, 1'b1, 1'b0, "R7");
    cycle(16'hC000, 10'h3C0, 1'b1, 1'b0, "R7");
    peek(16'hD000, 2'd0, 2'd0, "R7 no load");

    // R9: opcode in pages 0..5 loads nothing; page 5/6 boundary
    cycle(16'h5FFF, 10'h1C0, 1'b1, 1'b0, "R9");
    cycle(16'h2000, 10'h180, 1'b1, 1'b0, "R9");
    peek(16'h5000, 2'd0, 2'd0, "R9 page5");
    cycle(16'h6000, 10'h140, 1'b1, 1'b0, "R9 page6");
    peek(16'h7FFF, 2'd1, 2'd2, "R5 page7");
    cycle(16'hF000, 10'h180, 1'b1, 1'b0, "R5");
    peek(16'hEFFF, 2'd2, 2'd1, "R5 pageE");
    sweep("R6 R10");

    // R2: power-on pulse beats a simultaneous opcode
    cycle(16'h6000, 10'h1C0, 1'b1, 1'b1, "R2");
    peek(16'h6000, 2'd0, 2'd0, "R2 cleared");
    sweep("R2");

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [9:0] w;
      w = ($urandom % 2) ? ops[$urandom % 4] : 10'($urandom);
      cycle(16'($urandom), w, ($urandom % 5) != 0, ($urandom % 64) == 0, "R10 random");
      if (n % 500 == 499) sweep("R6 R7 random");
    end

    // R1: asynchronous reset mid-run
    cycle(16'h8000, 10'h1C0, 1'b1, 1'b0, "R10");
    @(negedge clk);
    rst_n = 1'b0;
    clear_model();
    sweep("R1 mid-run");
    rst_n = 1'b1;
    sweep("R1 after");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule